// File: doc/BRIEF.md
# Interrupt Controller with Deferred Master Enable

This block arbitrates five maskable interrupt sources for a small processor core. It holds a source-enable register, a pending-request register and a three-state master-enable machine. A one-cycle strobe from any source latches that source's request bit. The core writes and reads the two registers through a narrow register port. It signals the enable-interrupts and disable-interrupts instructions with single-cycle pulses.

At every instruction boundary the core raises a boundary strobe. In that same cycle the controller answers combinationally whether an interrupt is taken, and if so which source and which vector. At the following clock edge it clears the taken request bit and drops the master enable. The enable instruction does not open the gate at once. It schedules the enable, and the next boundary only promotes it, so one more whole instruction runs before any dispatch. Pushing the return address and jumping are left to the core.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable register reads 0x00, the request register reads 0xE0 (low five bits clear) and the master enable is off, so a boundary takes nothing.
- R2: A strobe on `src_pulse[i]` sets request bit i at the next edge whatever the enable register holds. Bit 0 is vertical blank, 1 display status, 2 timer, 3 serial and 4 keypad.
- R3: With `reg_sel`=0 the register port addresses the enable register, and with `reg_sel`=1 the request register. Only bits 4:0 are stored. Enable bits 7:5 read as 0, request bits 7:5 read as 1, and writes to bits 7:5 have no effect.
- R4: An enable pulse moves the master enable from off to scheduled. The first boundary after that promotes it to on without taking an interrupt. An enable pulse while on leaves it on.
- R5: An interrupt is taken only in a cycle with `boundary` high, the master enable already on and (enable AND request) nonzero in bits 4:0.
- R6: When several enabled requests are pending, the lowest-numbered one is taken and reported on `irq_idx`.
- R7: The reported vector is 0x40 + 8 × `irq_idx` (0x40, 0x48, 0x50, 0x58, 0x60).
- R8: At the edge after a take, only the taken request bit clears, other requests stay, and the master enable returns to off.
- R9: A disable pulse forces the master enable to off at the next edge from any state, which cancels a scheduled enable.
- R10: A source strobe in the same cycle as a request-register write, or as the clear of a take, leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NUM_SRC | One-cycle request strobes, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the enable register, 1 the request register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| ei_pulse | input | 1 | Enable-interrupts instruction pulse |
| di_pulse | input | 1 | Disable-interrupts instruction pulse |
| boundary | input | 1 | Instruction-boundary check strobe |
| irq_take | output | 1 | Interrupt taken at this boundary |
| irq_idx | output | IDX_W | Index of the selected source |
| irq_vec | output | VEC_W | Vector address of the selected source |

## Verification
The bench builds the block with its defaults: five sources, an 8-bit register port and 8-bit vectors. This leaves three padding bits, which makes the read-as-one and read-as-zero rules and the ignored upper write bits visible. Every vector from 0x40 to 0x60 falls within reach, as do all three master-enable states, the cancel of a scheduled enable, masked-but-pending requests and collisions between strobes and register writes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        IME_OFF   = 2'd0,
        IME_SCHED = 2'd1,
        IME_ON    = 2'd2
    } ime_t;
endpackage

// File: rtl/irqc_prio.sv
// Fixed-priority selector: the lowest set bit wins; vector derived from index.
module irqc_prio #(
    parameter int NUM_SRC  = 5,
    parameter int IDX_W    = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_STEP = 8
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [NUM_SRC-1:0] grant,
    output logic [IDX_W-1:0]   idx,
    output logic [VEC_W-1:0]   vec
);
    genvar g;
    for (g = 0; g < NUM_SRC; g++) begin : g_grant
        if (g == 0) begin : g_first
            assign grant[g] = req[0];
        end else begin : g_rest
            assign grant[g] = req[g] && !(|req[g-1:0]);
        end
    end

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

    assign vec = VEC_W'(VEC_BASE + VEC_STEP * int'(idx));
endmodule

// File: rtl/irqc_regs.sv
// Enable and request registers with padded read-back.
module irqc_regs #(
    parameter int NUM_SRC = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] set_mask,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] fl_q,
    output logic [DATA_W-1:0]  rdata
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] fl;
    } regs_t;

    regs_t st_d, st_q;
    logic  unused_wdata_hi;
    logic [NUM_SRC-1:0] fl_base;

    assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        st_d = st_q;
        if (wr_en && !sel) st_d.en = wdata[NUM_SRC-1:0];
        fl_base = (wr_en && sel) ? wdata[NUM_SRC-1:0] : st_q.fl;
        // strobes are applied last so they survive writes and clears
        st_d.fl = (fl_base & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign fl_q  = st_q.fl;
    assign rdata = sel ? {{PAD_W{1'b1}}, st_q.fl} : {{PAD_W{1'b0}}, st_q.en};
endmodule

// File: rtl/irqc_ime.sv
// Master-enable state machine with one-boundary deferral.
module irqc_ime
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ei,
    input  logic di,
    input  logic boundary,
    input  logic pending,
    output logic take,
    output ime_t state_q
);
    typedef struct packed {
        ime_t st;
    } ime_reg_t;

    ime_reg_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        take = boundary && (r_q.st == IME_ON) && pending;
        if (di) begin
            r_d.st = IME_OFF;
        end else begin
            case (r_q.st)
                IME_OFF:   if (ei)       r_d.st = IME_SCHED;
                IME_SCHED: if (boundary) r_d.st = IME_ON;
                IME_ON:    if (take)     r_d.st = IME_OFF;
                default:                 r_d.st = IME_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= IME_OFF;
        else        r_q    <= r_d;
    end

    assign state_q = r_q.st;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 5,
    parameter int DATA_W   = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_STEP = 8,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               ei_pulse,
    input  logic               di_pulse,
    input  logic               boundary,
    output logic               irq_take,
    output logic [IDX_W-1:0]   irq_idx,
    output logic [VEC_W-1:0]   irq_vec
);
    logic [NUM_SRC-1:0] en_q, fl_q, req, grant, clr_mask;
    logic               pending;
    ime_t               ime_q;

    assign req      = en_q & fl_q;
    assign clr_mask = irq_take ? grant : '0;

    irqc_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .set_mask (src_pulse),
        .clr_mask (clr_mask),
        .en_q     (en_q),
        .fl_q     (fl_q),
        .rdata    (reg_rdata)
    );

    irqc_prio #(
        .NUM_SRC (NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_prio (
        .req   (req),
        .any   (pending),
        .grant (grant),
        .idx   (irq_idx),
        .vec   (irq_vec)
    );

    irqc_ime u_ime (
        .clk      (clk),
        .rst_n    (rst_n),
        .ei       (ei_pulse),
        .di       (di_pulse),
        .boundary (boundary),
        .pending  (pending),
        .take     (irq_take),
        .state_q  (ime_q)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 5,
    parameter int IDX_W    = 3,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_STEP = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               boundary,
    input logic               ei,
    input logic               di,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] fl_q,
    input ime_t               ime_q,
    input logic               take,
    input logic [IDX_W-1:0]   idx,
    input logic [VEC_W-1:0]   vec
);
    logic [NUM_SRC-1:0] below;
    assign below = (NUM_SRC'(1) << idx) - NUM_SRC'(1);

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) take |-> boundary); // R5
    AST_TAKE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) take |-> ((en_q & fl_q) != '0)); // R5
    AST_TAKE_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n) take |-> ((en_q & fl_q & below) == '0)); // R6
    AST_VECTOR_MAP: assert property (@(posedge clk) disable iff (!rst_n) take |-> (vec == VEC_W'(VEC_BASE + VEC_STEP * int'(idx)))); // R7
    AST_EI_SCHEDULES: assert property (@(posedge clk) disable iff (!rst_n) (ei && !di && ime_q == IME_OFF) |=> (ime_q == IME_SCHED)); // R4
    AST_SCHED_PROMOTES: assert property (@(posedge clk) disable iff (!rst_n) (boundary && !di && ime_q == IME_SCHED) |=> (ime_q == IME_ON)); // R4
    AST_TAKE_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) take |=> (ime_q == IME_OFF)); // R8
    AST_DI_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n) di |=> (ime_q == IME_OFF)); // R9

    genvar g;
    for (g = 0; g < NUM_SRC; g++) begin : g_pulse
        AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n) src_pulse[g] |=> fl_q[g]); // R2
    end
endmodule

bind irqc_top irqc_chk #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .ei(ei_pulse), .di(di_pulse),
    .src_pulse(src_pulse), .en_q(en_q), .fl_q(fl_q), .ime_q(ime_q),
    .take(irq_take), .idx(irq_idx), .vec(irq_vec)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_pulse = '0;
    logic            reg_wr = 1'b0;
    logic            reg_sel = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            ei_pulse = 1'b0;
    logic            di_pulse = 1'b0;
    logic            boundary = 1'b0;
    logic            irq_take;
    logic [2:0]      irq_idx;
    logic [7:0]      irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    take;
        int    idx;
        int    vec;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ei_pulse(ei_pulse), .di_pulse(di_pulse), .boundary(boundary),
        .irq_take(irq_take), .irq_idx(irq_idx), .irq_vec(irq_vec)
    );

    // Monitor: compares each boundary answer against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && boundary) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL boundary with empty scoreboard: take=%0d exp=none", irq_take);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (irq_take !== e.take ||
                    (e.take && (int'(irq_idx) != e.idx || int'(irq_vec) != e.vec))) begin
                    errors++;
                    $display("FAIL %s: take=%0d idx=%0d vec=0x%0h exp take=%0d idx=%0d vec=0x%0h",
                             e.tag, irq_take, irq_idx, irq_vec, e.take, e.idx, e.vec);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] m);
        src_pulse = m;
        step();
        src_pulse = '0;
    endtask

    task automatic do_ei();
        ei_pulse = 1'b1; step(); ei_pulse = 1'b0;
    endtask

    task automatic do_di();
        di_pulse = 1'b1; step(); di_pulse = 1'b0;
    endtask

    // Driver: pushes the expected answer, then raises the boundary strobe.
    task automatic bnd(input bit t, input int i, input string tag);
        exp_t e;
        e.take = t; e.idx = i; e.vec = 64 + 8 * i; e.tag = tag;
        sb_q.push_back(e);
        boundary = 1'b1;
        step();
        boundary = 1'b0;
    endtask

    task automatic rd(input bit sel, input logic [7:0] exp, input string tag);
        reg_sel = sel;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=0x%0h exp=0x%0h", tag, reg_rdata, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, 8'h00, "R1 enable after reset");
        rd(1'b1, 8'hE0, "R1 request after reset");
        bnd(1'b0, 0, "R1 no take after reset");

        // R3 register port padding
        wr(1'b0, 8'hFF); rd(1'b0, 8'h1F, "R3 enable upper bits read 0");
        wr(1'b1, 8'h1F); rd(1'b1, 8'hFF, "R3 request upper bits read 1");
        wr(1'b1, 8'h00); rd(1'b1, 8'hE0, "R3 request write clears low bits");

        // R2 strobes set bits regardless of enable
        wr(1'b0, 8'h00);
        pulse(5'b00100); rd(1'b1, 8'hE4, "R2 timer strobe with enable off");
        pulse(5'b10000); rd(1'b1, 8'hF4, "R2 keypad strobe accumulates");
        wr(1'b1, 8'h00);

        // R4/R5/R7/R8 deferred enable then dispatch
        wr(1'b0, 8'h1F);
        pulse(5'b01000);
        bnd(1'b0, 0, "R5 master off blocks dispatch");
        do_ei();
        bnd(1'b0, 0, "R4 promoting boundary takes nothing");
        bnd(1'b1, 3, "R7 serial vector 0x58");
        rd(1'b1, 8'hE0, "R8 taken bit cleared");
        bnd(1'b0, 0, "R8 master off after take");

        // R6 priority
        pulse(5'b10010);
        do_ei();
        bnd(1'b0, 0, "R4 promote before priority test");
        bnd(1'b1, 1, "R6 lowest index first");
        rd(1'b1, 8'hF0, "R8 other request kept");
        bnd(1'b0, 0, "R8 no take until re-enabled");
        do_ei();
        bnd(1'b0, 0, "R4 promote again");
        bnd(1'b1, 4, "R7 keypad vector 0x60");

        // R9 disable cancels
        pulse(5'b00001);
        do_ei();
        do_di();
        bnd(1'b0, 0, "R9 scheduled enable cancelled");
        bnd(1'b0, 0, "R9 still off");
        do_ei();
        bnd(1'b0, 0, "R4 promote before disable");
        do_di();
        bnd(1'b0, 0, "R9 disable after on");
        do_ei();
        bnd(1'b0, 0, "R4 promote");
        bnd(1'b1, 0, "R7 vblank vector 0x40");

        // R5 masked requests
        wr(1'b0, 8'h02);
        rd(1'b0, 8'h02, "R3 enable readback");
        pulse(5'b00101);
        do_ei();
        bnd(1'b0, 0, "R4 promote with masked requests");
        bnd(1'b0, 0, "R5 masked requests not taken");
        wr(1'b0, 8'h04);
        bnd(1'b1, 2, "R7 timer vector 0x50");
        rd(1'b1, 8'hE1, "R8 only timer bit cleared");

        // R10 strobe beats a register write
        src_pulse = 5'b00010;
        wr(1'b1, 8'h00);
        src_pulse = '0;
        rd(1'b1, 8'hE2, "R10 strobe survives write");

        step();
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard leftover: %0d exp 0", sb_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired: done=0 exp=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule